// File: doc/BRIEF.md
# Fractional microsecond tick generator

This block derives a 1 MHz tick enable from a faster reference clock whose frequency need not be an integer multiple of 1 MHz. A rational ratio is programmed as two byte fields. An accumulator spreads the resulting ticks evenly over each averaging window, so references such as 19.2 MHz or 12.8 MHz still give an exact average of one tick per microsecond.

Each tick is a one-clock pulse that downstream timers use as a count enable. The block also keeps a free-running 32-bit microsecond count that advances on every tick. A hold control stops the count without disturbing tick generation.

Software reaches the ratio, the count and the hold control through a small register port. The port has a write strobe, an address, write data and combinational read data.

Top module: `us_tick_gen`

## Requirements
- R1: After reset, tick_o is low, the count reads 0, the ratio register reads 0x0000000B and the hold bit reads 0.
- R2: The ratio register at address 0x14 holds a divisor field L in bits [7:0] and a multiplier field H in bits [15:8]. When H < L, H+1 ticks are produced per L+1 clocks. The k-th tick after a ratio write appears in the cycle that follows ceil(k*(L+1)/(H+1)) rising edges counted from the write edge.
- R3: Each tick is high for exactly one clock. When H >= L, a tick is produced on every clock after the write.
- R4: A write to the ratio register restarts the phase. tick_o is low in the cycle after the write edge, and R2 timing counts from that edge.
- R5: The count advances by one on the clock edge that ends each tick cycle.
- R6: Bit 0 of address 0x4C is the hold bit. While it is 1 the count keeps its value, but ticks keep being produced on the same schedule.
- R7: The count wraps from 0xFFFFFFFF to 0x00000000.
- R8: A write to address 0x10 loads the count with the write data. A load takes priority over a tick in the same cycle.
- R9: Reads return the count at 0x10, the ratio at 0x14 with bits [31:16] as zero, the hold bit at 0x4C and zero at any other address. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| tick_o | output | 1 | One-clock 1 MHz tick enable |

## Verification
The bench predicts the exact cycle of every tick from the ceiling formula. An off-by-one in the plus-one fields, a strict comparison in place of greater-or-equal, or an accumulator that is not cleared on a ratio write would move ticks by a cycle. The bench also checks the multiplier-above-divisor case, where a design without bounding would let the accumulator run away and drop ticks. The count is shadowed every cycle. This catches a hold that also stalls the ticks, a lost wrap, and a load that loses to a simultaneous tick. Decode checks catch aliasing of unmapped addresses onto the ratio register and stray upper ratio bits.

// File: rtl/us_tick_pkg.sv
package us_tick_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] CNT_ADDR = 8'h10;
  localparam logic [ADDR_W-1:0] CFG_ADDR = 8'h14;
  localparam logic [ADDR_W-1:0] HOLD_ADDR = 8'h4C;

  typedef struct packed {
    logic [7:0] hi;  // ticks per window minus one
    logic [7:0] lo;  // clocks per window minus one
  } ratio_cfg_t;
endpackage

// File: rtl/us_ratio_accum.sv
module us_ratio_accum
  import us_tick_pkg::*;
#(
  parameter int unsigned FW = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  ratio_cfg_t cfg_i,
  input  logic       restart_i,
  output logic       tick_o
);
  localparam int unsigned AW = FW + 2;

  logic [AW-1:0] acc_q, num, den, sum, rem, acc_d;
  logic          hit;

  assign num = {2'b00, cfg_i.hi} + AW'(1);
  assign den = {2'b00, cfg_i.lo} + AW'(1);
  assign sum = acc_q + num;
  assign hit = (sum >= den);
  assign rem = sum - den;

  // bound the accumulator when the multiplier exceeds the divisor
  always_comb begin
    if (!hit)            acc_d = sum;
    else if (rem >= den) acc_d = '0;
    else                 acc_d = rem;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (restart_i) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_o <= hit;
    end
  end

  assert_restart_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!tick_o && acc_q == '0));

  assert_acc_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < den);

  assert_dense_ratio_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && cfg_i.hi >= cfg_i.lo) |=> tick_o);
endmodule

// File: rtl/us_counter.sv
module us_counter #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          hold_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (load_i)            cnt_o <= load_val_i;
    else if (tick_i && !hold_i) cnt_o <= cnt_o + CW'(1);
  end

  assert_count_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !hold_i && !load_i) |=> cnt_o == $past(cnt_o) + CW'(1));

  assert_hold_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !load_i) |=> $stable(cnt_o));

  assert_load_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == $past(load_val_i));
endmodule

// File: rtl/us_tick_regs.sv
module us_tick_regs
  import us_tick_pkg::*;
#(
  parameter int unsigned    DW        = 32,
  parameter logic [15:0]    RESET_CFG = 16'h000B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     cnt_i,
  output ratio_cfg_t        cfg_o,
  output logic              cfg_wr_o,
  output logic              cnt_wr_o,
  output logic              hold_o,
  output logic [DW-1:0]     rdata_o
);
  localparam int unsigned CFG_W = $bits(ratio_cfg_t);

  logic hold_wr;

  assign cfg_wr_o = wr_en_i && (addr_i == CFG_ADDR);
  assign cnt_wr_o = wr_en_i && (addr_i == CNT_ADDR);
  assign hold_wr  = wr_en_i && (addr_i == HOLD_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= ratio_cfg_t'(RESET_CFG);
      hold_o <= 1'b0;
    end else begin
      if (cfg_wr_o) cfg_o  <= ratio_cfg_t'(wdata_i[CFG_W-1:0]);
      if (hold_wr)  hold_o <= wdata_i[0];
    end
  end

  always_comb begin
    unique case (addr_i)
      CNT_ADDR:  rdata_o = cnt_i;
      CFG_ADDR:  rdata_o = DW'(cfg_o);
      HOLD_ADDR: rdata_o = DW'(hold_o);
      default:   rdata_o = '0;
    endcase
  end

  assert_cfg_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o |=> cfg_o == $past(wdata_i[CFG_W-1:0]));

  assert_cfg_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wr_o |=> $stable(cfg_o));
endmodule

// File: rtl/us_tick_gen.sv
module us_tick_gen
  import us_tick_pkg::*;
#(
  parameter int unsigned FW        = 8,
  parameter int unsigned CW        = 32,
  parameter logic [15:0] RESET_CFG = 16'h000B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CW-1:0]     wdata_i,
  output logic [CW-1:0]     rdata_o,
  output logic              tick_o
);
  ratio_cfg_t    cfg;
  logic          cfg_wr, cnt_wr, hold;
  logic [CW-1:0] cnt;

  us_tick_regs #(.DW(CW), .RESET_CFG(RESET_CFG)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .cnt_i(cnt), .cfg_o(cfg), .cfg_wr_o(cfg_wr), .cnt_wr_o(cnt_wr),
    .hold_o(hold), .rdata_o
  );

  us_ratio_accum #(.FW(FW)) u_accum (
    .clk_i, .rst_ni, .cfg_i(cfg), .restart_i(cfg_wr), .tick_o
  );

  us_counter #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick_o), .hold_i(hold),
    .load_i(cnt_wr), .load_val_i(wdata_i), .cnt_o(cnt)
  );

  assert_tick_after_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == CFG_ADDR) |=> !tick_o);
endmodule

// File: tb/us_tick_gen_bench.sv
`timescale 1ns/1ps
module us_tick_gen_bench;
  import us_tick_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = CNT_ADDR;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick;

  us_tick_gen u_us_tick_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_o(tick)
  );

  always #5 clk = ~clk;

  int compared = 0, mismatched = 0, cyc = 0;
  int exp_q[$];
  bit mon_on = 0, cnt_on = 0, hold_m = 0, done = 0;
  logic [31:0] exp_cnt = '0;
  string cur_req = "R2";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: tick schedule and count shadow
  always @(negedge clk) begin
    if (mon_on && exp_q.size() > 0) begin
      if (exp_q[0] == cyc) begin
        check(tick == 1'b1, cur_req, 32'(tick), 32'd1);
        void'(exp_q.pop_front());
      end else if (exp_q[0] < cyc) begin
        check(1'b0, cur_req, 32'd0, 32'd1);
        void'(exp_q.pop_front());
      end else if (tick) begin
        check(1'b0, cur_req, 32'd1, 32'd0);
      end
    end
    if (cnt_on) begin
      if (addr == CNT_ADDR && !wr_en)
        check(rdata == exp_cnt, (cur_req == "R7") ? "R7" : (cur_req == "R8") ? "R8" : "R5", rdata, exp_cnt);
      if (tick && !hold_m) exp_cnt = exp_cnt + 32'd1;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    if (a == CNT_ADDR) cnt_on = 0;
    @(posedge clk); #1;
    wr_en = 1'b0; addr = CNT_ADDR;
    if (a == CNT_ADDR) begin exp_cnt = d; cnt_on = 1; end
    if (a == HOLD_ADDR) hold_m = d[0];
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(posedge clk); #1; addr = a;
    @(negedge clk);
    check(rdata == exp, req, rdata, exp);
    @(posedge clk); #1; addr = CNT_ADDR;
  endtask

  task automatic run_cfg(input logic [15:0] c, input int k, input string req);
    int wcyc, num, den;
    mon_on = 0; exp_q.delete(); cur_req = req;
    @(posedge clk); #1;
    wr_en = 1'b1; addr = CFG_ADDR; wdata = {16'hA5C3, c};
    @(posedge clk); #1;
    wr_en = 1'b0; addr = CNT_ADDR; wcyc = cyc;
    num = int'(c[15:8]) + 1; den = int'(c[7:0]) + 1;
    for (int kk = 1; kk <= k; kk++) begin
      if (num >= den) exp_q.push_back(wcyc + kk);
      else            exp_q.push_back(wcyc + (kk * den + num - 1) / num);
    end
    mon_on = 1;
    @(negedge clk);
    check(tick == 1'b0, "R4", 32'(tick), 32'd0);
  endtask

  task automatic wait_q();
    while (exp_q.size() > 0) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check(tick == 1'b0, "R1", 32'(tick), 32'd0);
    check(rdata == 32'd0, "R1", rdata, 32'd0);
    rd(CFG_ADDR, 32'h0000000B, "R1");
    rd(HOLD_ADDR, 32'd0, "R1");
    cnt_on = 1;

    // R2 ratios for several references
    run_cfg(16'h000B, 6, "R2"); wait_q();
    run_cfg(16'h045F, 10, "R2"); wait_q();
    rd(CFG_ADDR, 32'h0000045F, "R9");
    run_cfg(16'h043F, 10, "R2"); wait_q();
    run_cfg(16'h04BF, 5, "R2"); wait_q();
    run_cfg(16'h002F, 3, "R2"); wait_q();
    // R4 restart mid-window
    run_cfg(16'h045F, 2, "R4");
    repeat (7) @(posedge clk);
    run_cfg(16'h045F, 5, "R4"); wait_q();
    // R3 dense ratios
    run_cfg(16'h0000, 8, "R3"); wait_q();
    run_cfg(16'h0302, 8, "R3"); wait_q();
    run_cfg(16'h0707, 8, "R3"); wait_q();

    // R6 hold: count frozen, ticks keep their schedule
    begin
      logic [31:0] snap;
      run_cfg(16'h000B, 12, "R6");
      repeat (5) @(posedge clk);
      wr(HOLD_ADDR, 32'd1);
      rd(HOLD_ADDR, 32'd1, "R6");
      @(negedge clk); snap = rdata;
      repeat (40) @(posedge clk);
      @(negedge clk);
      check(rdata == snap, "R6", rdata, snap);
      wait_q();
      wr(HOLD_ADDR, 32'd0);
    end

    // R9 unmapped write ignored, reads zero
    wr(8'h20, 32'hFFFF_FFFF);
    rd(CFG_ADDR, 32'h0000000B, "R9");
    rd(8'h20, 32'd0, "R9");
    rd(HOLD_ADDR, 32'd0, "R9");

    // R8 load, including collision with tick every clock
    cur_req = "R8";
    run_cfg(16'h0000, 4, "R8"); wait_q();
    cur_req = "R8";
    wr(CNT_ADDR, 32'h1234_5678);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(rdata >= 32'h1234_5678 && rdata <= 32'h1234_5678 + 32'd11, "R8", rdata, 32'h1234_5678);

    // R7 wrap
    cur_req = "R7";
    wr(CNT_ADDR, 32'hFFFF_FFFD);
    repeat (12) @(posedge clk);
    @(negedge clk);
    check(rdata < 32'd16, "R7", rdata, 32'd9);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=%0d expected=finished", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule